// File: doc/BRIEF.md
# Local Interrupt Timer

This block is a per-processor interval timer. Software programs it through a narrow register port: a timer entry that holds an interrupt vector, a mask bit and a periodic-mode select; an initial-count register that starts a countdown; a divide register that sets the prescale ratio; and a read-only current-count register. The 32-bit counter steps down once per prescaled tick. When it reaches zero the block emits a one-cycle interrupt request that carries the programmed vector. The request is always edge-triggered and of the fixed delivery kind.

In one-shot mode the counter stops at zero and the timer disarms. In periodic mode the next tick after zero reloads the initial count, so each period lasts the initial count plus one tick. Every output is registered. A write cycle freezes the countdown for that cycle, so software never races a decrement.

Top module: `ltmr_top`

## Requirements
- R1: A write to the divide register (address 3) stores only data bits 3, 1 and 0. A read of address 3 returns the stored value with every other bit zero.
- R2: The divide code is {bit 3, bit 1, bit 0} of the divide register. The counter steps once every 2^((code+1) mod 8) clocks, so code 7 steps every clock and code 4 steps every 32 clocks.
- R3: A write to the initial-count register (address 1) loads the counter with the written value and restarts the prescaler. It arms the timer when the value is nonzero and disarms it when the value is zero.
- R4: In one-shot mode (entry bit 17 clear), the counter steps down to zero and then stays at zero with no further requests.
- R5: In the first cycle that the counter holds zero after stepping down from 1, `irq_valid` is high for exactly one cycle, and `irq_vector` carries entry bits 7:0.
- R6: With entry bit 16 (mask) set, expiry raises no request, but counting goes on.
- R7: In periodic mode (entry bit 17 set), the tick after zero reloads the initial count, giving one request every (initial+1) ticks.
- R8: A write to the timer entry (address 0) keeps bits 17, 16 and 7:0 and reads back with all other bits zero. It re-arms the timer exactly when the initial count is nonzero and either periodic mode is selected or the counter is nonzero.
- R9: A read of address 2 returns the live counter value. Writes to address 2 change nothing.
- R10: The counter does not step in any cycle in which a register write occurs.
- R11: After reset, all registers read zero, the timer is disarmed and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 entry, 1 initial count, 2 current count, 3 divide |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | DATA_W | Registered read data for the address of the previous cycle |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | VEC_W | Vector of the request, valid with irq_valid |

## Verification
The bench builds the block with its default 32-bit data width. It uses small initial counts (0, 1, 3, 5) and large ones, so that one-shot expiry, periodic reload and the zero-count disarm all happen within a few hundred cycles. Divide codes 7, 0 and 4 cover the one-clock, two-clock and thirty-two-clock tick rates, and the spacing between periodic requests is measured directly at codes 0 and 4. A behavioural model is compared with the outputs on every clock, while masked expiry, rearming through an entry write and the freeze during back-to-back writes each get a directed check.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int VEC_BIT_W  = 8;
  localparam int MASK_POS   = 16;
  localparam int PER_POS    = 17;
  localparam int CODE_W     = 3;
  localparam int PRE_W      = (1 << CODE_W) - 1;
  localparam int DIV_W      = 4;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'b1011;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  // prescale shift: code {b3,b1,b0}, shift = (code + 1) mod 8
  function automatic logic [CODE_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [CODE_W-1:0] code;
    code = {d[3], d[1:0]};
    return code + CODE_W'(1);
  endfunction
endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
  import ltmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [CODE_W-1:0] shift,
  output logic              tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] lim;

  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_lim
      assign lim[i] = (shift > CODE_W'(i));
    end
  endgenerate

  assign tick = ((pcnt & lim) == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/ltmr_regs.sv
module ltmr_regs
  import ltmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = VEC_BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [DATA_W-1:0] count,
  output logic [VEC_W-1:0]  ent_vec,
  output logic              ent_mask,
  output logic              ent_per,
  output logic [DATA_W-1:0] init_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              ld_init,
  output logic              wr_entry,
  output logic              wr_div,
  output logic [DATA_W-1:0] rd_data
);
  reg_sel_e wsel, rsel;
  logic [DATA_W-1:0] entry_word;
  logic [DATA_W-1:0] rd_next;

  assign wsel     = reg_sel_e'(wr_addr);
  assign rsel     = reg_sel_e'(rd_addr);
  assign ld_init  = wr_en && (wsel == SEL_INIT);
  assign wr_entry = wr_en && (wsel == SEL_ENTRY);
  assign wr_div   = wr_en && (wsel == SEL_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vec  <= '0;
      ent_mask <= 1'b0;
      ent_per  <= 1'b0;
      init_q   <= '0;
      div_q    <= '0;
    end else begin
      if (wr_entry) begin
        ent_vec  <= wr_data[VEC_W-1:0];
        ent_mask <= wr_data[MASK_POS];
        ent_per  <= wr_data[PER_POS];
      end
      if (ld_init) init_q <= wr_data;
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0] & DIV_KEEP;
    end
  end

  always_comb begin
    entry_word                = '0;
    entry_word[VEC_W-1:0]     = ent_vec;
    entry_word[MASK_POS]      = ent_mask;
    entry_word[PER_POS]       = ent_per;
  end

  always_comb begin
    unique case (rsel)
      SEL_ENTRY: rd_next = entry_word;
      SEL_INIT:  rd_next = init_q;
      SEL_COUNT: rd_next = count;
      SEL_DIV:   rd_next = DATA_W'(div_q);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/ltmr_count.sv
module ltmr_count #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_init,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_q,
  input  logic             entry_wr,
  input  logic             entry_per_new,
  input  logic             hold,
  input  logic             tick,
  input  logic             per,
  input  logic             mask,
  input  logic [VEC_W-1:0] vec,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic at_zero, at_one;

  assign at_zero = (count == '0);
  assign at_one  = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      armed      <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (ld_init) begin
        count <= load_val;
        armed <= |load_val;
      end else if (entry_wr) begin
        armed <= (|init_q) && (entry_per_new || !at_zero);
      end else if (!hold && tick && armed) begin
        if (at_zero) begin
          count <= init_q;
        end else begin
          count <= count - CNT_W'(1);
          if (at_one) begin
            irq_valid <= !mask;
            if (!mask) irq_vector <= vec;
            if (!per)  armed <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = VEC_BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0]  ent_vec;
  logic              ent_mask, ent_per;
  logic [DATA_W-1:0] init_q, count;
  logic [DIV_W-1:0]  div_q;
  logic              ld_init, wr_entry, wr_div;
  logic              tick, armed;

  ltmr_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .count(count), .ent_vec(ent_vec), .ent_mask(ent_mask),
    .ent_per(ent_per), .init_q(init_q), .div_q(div_q), .ld_init(ld_init),
    .wr_entry(wr_entry), .wr_div(wr_div), .rd_data(rd_data)
  );

  ltmr_prescale u_pre (
    .clk(clk), .rst(rst), .clear(ld_init || wr_div),
    .shift(div_to_shift(div_q)), .tick(tick)
  );

  ltmr_count #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst(rst), .ld_init(ld_init), .load_val(wr_data), .init_q(init_q),
    .entry_wr(wr_entry), .entry_per_new(wr_data[PER_POS]), .hold(wr_en),
    .tick(tick), .per(ent_per), .mask(ent_mask), .vec(ent_vec),
    .count(count), .armed(armed), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/ltmr_checker.sv
module ltmr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_valid,
  input logic [DATA_W-1:0] count,
  input logic              armed,
  input logic              ent_mask,
  input logic [3:0]        div_q
);
  AST_DIV_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3) |=> (div_q == ($past(wr_data[3:0]) & 4'b1011))); // R1

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> (count == $past(wr_data))); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && count != $past(count)) |->
      (count == $past(count) - 1 || $past(count) == '0)); // R4

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
    (!armed && !wr_en) |=> $stable(count)); // R4

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (count == '0)); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> !irq_valid); // R5

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(ent_mask)); // R6

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != 2'd1) |=> $stable(count)); // R10
endmodule

bind ltmr_top ltmr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_valid(irq_valid), .count(count), .armed(armed), .ent_mask(ent_mask),
  .div_q(div_q)
);

// File: tb/ltmr_top_test.sv
`timescale 1ns/1ps
module ltmr_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  always #2 clk = ~clk;

  ltmr_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  int n_vec = 0, n_bad = 0, cyc = 0, irq_seen = 0;
  bit started = 0, done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_entry, m_init, m_cnt, m_rd;
  logic [3:0]  m_div;
  int          m_pre;
  bit          m_armed, m_irq;
  logic [7:0]  m_vec;
  logic [1:0]  m_rda;

  always @(posedge clk) begin : model
    int sh, per_len;
    bit tk;
    sh = ((m_div[3] ? 4 : 0) + m_div[1:0] + 1) % 8;
    per_len = 1 << sh;
    tk = ((m_pre + 1) % per_len) == 0;
    if (rst) begin
      m_entry = 0; m_init = 0; m_cnt = 0; m_div = 0; m_pre = 0;
      m_armed = 0; m_irq = 0; m_vec = 0; m_rd = 0; m_rda = 0;
    end else begin
      case (rd_addr)
        2'd0: m_rd = m_entry;
        2'd1: m_rd = m_init;
        2'd2: m_rd = m_cnt;
        default: m_rd = {28'd0, m_div};
      endcase
      m_rda = rd_addr;
      m_irq = 0;
      m_pre = (m_pre + 1) % 128;
      if (wr_en) begin
        if (wr_addr == 2'd0) begin
          m_entry = wr_data & 32'h0003_00FF;
          m_armed = (m_init != 0) && (wr_data[17] || m_cnt != 0);
        end else if (wr_addr == 2'd1) begin
          m_init = wr_data; m_cnt = wr_data; m_armed = (wr_data != 0); m_pre = 0;
        end else if (wr_addr == 2'd3) begin
          m_div = wr_data[3:0] & 4'hB; m_pre = 0;
        end
      end else if (tk && m_armed) begin
        if (m_cnt == 0) m_cnt = m_init;
        else begin
          if (m_cnt == 1) begin
            m_irq = !m_entry[16];
            if (m_irq) m_vec = m_entry[7:0];
            if (!m_entry[17]) m_armed = 0;
          end
          m_cnt = m_cnt - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      check("R5 irq_valid", {31'd0, irq_valid}, {31'd0, m_irq});
      if (m_irq) check("R5 irq_vector", {24'd0, irq_vector}, {24'd0, m_vec});
      case (m_rda)
        2'd0: check("R8 rd entry", rd_data, m_rd);
        2'd1: check("R3 rd init", rd_data, m_rd);
        2'd2: check("R9 rd count", rd_data, m_rd);
        default: check("R1 rd div", rd_data, m_rd);
      endcase
      if (irq_valid) irq_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_valid && n < limit);
  endtask

  initial begin
    logic [31:0] v, v2;
    int a, b, s0;
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0; started = 1;

    // R11 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); check("R11 reset read", v, 32'd0);
    end
    check("R11 reset irq", {31'd0, irq_valid}, 32'd0);

    // R1 divide bits kept
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R1 divide mask", v, 32'h0000_000B);
    // R8 entry readback
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R8 entry readback", v, 32'h0003_00FF);

    // R4/R5 one-shot at divide-by-1
    wr(2'd0, 32'h0000_0021);
    s0 = irq_seen;
    wr(2'd1, 32'd5);
    idle(20);
    check("R5 one request", irq_seen - s0, 1);
    rd(2'd2, v); check("R4 stays zero", v, 32'd0);
    idle(10);
    check("R4 no repeat", irq_seen - s0, 1);

    // R9 write to count ignored
    wr(2'd2, 32'h0000_1234); rd(2'd2, v); check("R9 count write ignored", v, 32'd0);

    // R8 rearm by entry write: periodic, init 5 nonzero, count 0
    wr(2'd0, 32'h0002_0033);
    wait_irq(50, a);
    check("R8 rearmed request", {31'd0, irq_valid}, 32'd1);
    check("R8 rearmed vector", {24'd0, irq_vector}, 32'h33);

    // R7 periodic, code 0 (two clocks per tick), init 3 -> 8 cycles
    wr(2'd0, 32'h0002_0040);
    wr(2'd3, 32'h0000_0000);
    wr(2'd1, 32'd3);
    wait_irq(200, a); wait_irq(200, b);
    check("R7 periodic spacing", b, 8);
    wait_irq(200, b);
    check("R7 periodic spacing again", b, 8);

    // R2 code 4 (32 clocks per tick), init 1 -> 64 cycles
    wr(2'd3, 32'h0000_0008);
    wr(2'd1, 32'd1);
    wait_irq(400, a); wait_irq(400, b);
    check("R2 code4 spacing", b, 64);

    // R6 masked: counting goes on, no request
    wr(2'd3, 32'h0000_000B);
    wr(2'd0, 32'h0003_0040);
    wr(2'd1, 32'd7);
    s0 = irq_seen;
    rd(2'd2, v);
    rd(2'd2, v2);
    check("R6 count moves", {31'd0, v != v2}, 32'd1);
    idle(40);
    check("R6 masked quiet", irq_seen - s0, 0);

    // R3 init zero disarms
    wr(2'd0, 32'h0002_0010);
    wr(2'd1, 32'd0);
    s0 = irq_seen;
    idle(40);
    check("R3 zero init quiet", irq_seen - s0, 0);
    rd(2'd2, v); check("R3 zero count", v, 32'd0);

    // R10 counter frozen during back-to-back writes
    wr(2'd1, 32'd1000);
    idle(3);
    rd_addr = 2'd2;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0002_0010;
    @(negedge clk); v = rd_data;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk); v2 = rd_data;
    check("R10 hold during writes", v2, v);
    idle(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule